// File: doc/BRIEF.md
# PLL Divider Parameter Search Engine

This block is a sequential engine that finds divider settings for a clock synthesizer. The synthesizer's output is `f_in * F / (2 * R * OD)`, where F is the feedback divider, R the reference divider and OD the output divider. The engine takes a reference frequency and a requested output frequency, both unsigned integers in Hz. It searches the (OD, R) space and returns the settings that give the highest achievable frequency found, together with that frequency.

The search covers only the OD values that keep the internal oscillator inside a fixed band. Within that band, OD steps upward in the outer loop and R steps upward in the inner loop. For each pair, the engine takes the floor feedback value and computes the resulting frequency. A pair replaces the best result only if its frequency is strictly higher. The search ends early when a new best result hits the request exactly. If no pair yields a nonzero frequency, the engine reports failure.

All divisions go through one shared restoring divider, which produces one quotient bit per clock. A one-cycle `start` launches a search and a one-cycle `done` marks its end.

Top module: `pll_param_search`

## Requirements
- R1: After reset, `busy`, `done`, `ok` and `fail` are 0, and `rate_o`, `fb_div`, `ref_div` and `out_div` are 0.
- R2: When `ok` is 1, `rate_o` equals floor(f_in * fb_div / (2 * ref_div * out_div)) for the `f_in` of that search.
- R3: When `ok` is 1, all of the following hold:
  - `out_div` lies between max(1, VCO_LO / f_req + 1) and min(OD_MAX, VCO_HI / f_req), using integer division.
  - `ref_div` lies in 1..R_MAX.
  - `fb_div` lies in 1..F_MAX.
- R4: Pairs are visited with OD ascending in the outer loop and R ascending in the inner loop. A pair becomes the best only if its frequency is strictly greater than the current best, so on a tie the earlier pair is kept.
- R5: For each pair, F = floor((f_req + 1) * 2 * R * OD / f_in). A pair with F = 0 is skipped. An F above F_MAX is clamped to F_MAX before the frequency is computed.
- R6: When a pair becomes the new best and its frequency equals `f_req` exactly, the search ends at once with that pair. No later pair is visited.
- R7: When no pair yields a nonzero frequency, `done` brings `fail` = 1, `ok` = 0, and zero on `rate_o`, `fb_div`, `ref_div` and `out_div`. This includes the case where the OD range is empty. On every `done`, exactly one of `ok` and `fail` is 1.
- R8: A `start` with `f_in` = 0 or `f_req` = 0 ends in failure, with no division performed.
- R9: A `start` pulse while `busy` is 1 is ignored. The running search completes with the inputs it latched.
- R10: `busy` rises the cycle after an accepted `start`. `done` is a one-cycle pulse in the cycle that `busy` falls. Results change only in a `done` cycle and hold until the next one.
- R11: The returned frequency never exceeds `f_req + 1`. The +1 slack comes from the rounding rule in R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a search |
| f_in | input | FREQ_W | Reference frequency in Hz |
| f_req | input | FREQ_W | Requested output frequency in Hz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| ok | output | 1 | Last search found a setting |
| fail | output | 1 | Last search found no setting |
| rate_o | output | FREQ_W+1 | Achieved frequency in Hz |
| fb_div | output | $clog2(F_MAX+1) | Chosen feedback divider F |
| ref_div | output | $clog2(R_MAX+1) | Chosen reference divider R |
| out_div | output | $clog2(OD_MAX+2) | Chosen output divider OD |

## Verification
The hardest situations to reach from the ports are these:
- the early exit on an exact match, which appears only as a shorter latency and as the choice of an earlier pair over a later pair that overshoots by one;
- the feedback clamp, which needs a slow reference and a fast request at the same time.

The bench uses a small configuration with scaled-down oscillator bounds and divider limits. This makes a full search only a few thousand cycles long, so a grid of reference and request values can be swept. The grid includes:
- an exact-match pair whose latency is measured;
- a slow-reference case that forces clamping;
- requests that empty the OD range;
- a very fast reference for which every F floors to zero.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LO,
        S_HI,
        S_FGO,
        S_FWAIT,
        S_RWAIT,
        S_NEXT
    } srch_state_e;

endpackage

// File: rtl/pll_div_unit.sv
module pll_div_unit #(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [DW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic          rdy,
    output logic [DW-1:0] quot
);
    localparam int CW = $clog2(DW + 1);

    typedef struct packed {
        logic          run;
        logic          rdy;
        logic [CW-1:0] cnt;
        logic [DW:0]   rem;
        logic [DW-1:0] quo;
        logic [DW-1:0] dvs;
    } div_t;

    div_t q, d;
    logic [DW:0] sh;

    always_comb begin
        d     = q;
        d.rdy = 1'b0;
        sh    = {q.rem[DW-1:0], q.quo[DW-1]};
        if (go) begin
            d.run = 1'b1;
            d.cnt = CW'(DW);
            d.rem = '0;
            d.quo = dividend;
            d.dvs = divisor;
        end else if (q.run) begin
            if (sh >= {1'b0, q.dvs}) begin
                d.rem = sh - {1'b0, q.dvs};
                d.quo = {q.quo[DW-2:0], 1'b1};
            end else begin
                d.rem = sh;
                d.quo = {q.quo[DW-2:0], 1'b0};
            end
            d.cnt = q.cnt - CW'(1);
            if (q.cnt == CW'(1)) begin
                d.run = 1'b0;
                d.rdy = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rdy  = q.rdy;
    assign quot = q.quo;

endmodule

// File: rtl/pll_param_search.sv
module pll_param_search
    import pll_search_pkg::*;
#(
    parameter int FREQ_W = 32,
    parameter int DIV_W  = 64,
    parameter int R_MAX  = 64,
    parameter int OD_MAX = 8,
    parameter int F_MAX  = 8192,
    parameter longint VCO_LO = 120000000,
    parameter longint VCO_HI = 600000000
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             start,
    input  logic [FREQ_W-1:0]                f_in,
    input  logic [FREQ_W-1:0]                f_req,
    output logic                             busy,
    output logic                             done,
    output logic                             ok,
    output logic                             fail,
    output logic [FREQ_W:0]                  rate_o,
    output logic [$clog2(F_MAX+1)-1:0]       fb_div,
    output logic [$clog2(R_MAX+1)-1:0]       ref_div,
    output logic [$clog2(OD_MAX+2)-1:0]      out_div
);
    localparam int RW   = $clog2(R_MAX + 1);
    localparam int ODW  = $clog2(OD_MAX + 2);
    localparam int FBW  = $clog2(F_MAX + 1);
    localparam int RODW = $clog2(2 * R_MAX * OD_MAX + 1);

    typedef struct packed {
        srch_state_e         st;
        logic [FREQ_W-1:0]   fin;
        logic [FREQ_W-1:0]   req;
        logic [ODW-1:0]      od_cur;
        logic [ODW-1:0]      od_hi;
        logic [RW-1:0]       r_cur;
        logic [FBW-1:0]      f_cur;
        logic [FREQ_W:0]     best_rate;
        logic [FBW-1:0]      best_f;
        logic [RW-1:0]       best_r;
        logic [ODW-1:0]      best_od;
        logic                done;
        logic                ok;
        logic                fail;
        logic [FREQ_W:0]     o_rate;
        logic [FBW-1:0]      o_f;
        logic [RW-1:0]       o_r;
        logic [ODW-1:0]      o_od;
        logic                div_go;
        logic [DIV_W-1:0]    div_a;
        logic [DIV_W-1:0]    div_b;
    } srch_t;

    srch_t q, d;

    logic             div_rdy;
    logic [DIV_W-1:0] div_q;

    pll_div_unit #(.DW(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (q.div_go),
        .dividend (q.div_a),
        .divisor  (q.div_b),
        .rdy      (div_rdy),
        .quot     (div_q)
    );

    logic            fin_now;
    logic [RODW-1:0] rod;
    logic [ODW-1:0]  hi;
    logic [FBW-1:0]  fnew;
    logic [FREQ_W:0] cur;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.div_go = 1'b0;
        fin_now  = 1'b0;
        rod      = RODW'(q.r_cur) * RODW'(q.od_cur) * RODW'(2);
        hi       = '0;
        fnew     = '0;
        cur      = div_q[FREQ_W:0];
        unique case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.fin       = f_in;
                    d.req       = f_req;
                    d.best_rate = '0;
                    d.best_f    = '0;
                    d.best_r    = '0;
                    d.best_od   = '0;
                    if (f_in == '0 || f_req == '0) begin
                        fin_now = 1'b1;
                    end else begin
                        d.div_a  = DIV_W'(VCO_LO);
                        d.div_b  = DIV_W'(f_req);
                        d.div_go = 1'b1;
                        d.st     = S_LO;
                    end
                end
            end
            S_LO: begin
                if (div_rdy) begin
                    if (div_q >= DIV_W'(OD_MAX)) d.od_cur = ODW'(OD_MAX + 1);
                    else                         d.od_cur = div_q[ODW-1:0] + ODW'(1);
                    d.div_a  = DIV_W'(VCO_HI);
                    d.div_b  = DIV_W'(q.req);
                    d.div_go = 1'b1;
                    d.st     = S_HI;
                end
            end
            S_HI: begin
                if (div_rdy) begin
                    if (div_q >= DIV_W'(OD_MAX)) hi = ODW'(OD_MAX);
                    else                         hi = div_q[ODW-1:0];
                    d.od_hi = hi;
                    if (hi == '0 || q.od_cur > hi) begin
                        fin_now = 1'b1;
                    end else begin
                        d.r_cur = RW'(1);
                        d.st    = S_FGO;
                    end
                end
            end
            S_FGO: begin
                d.div_a  = (DIV_W'(q.req) + DIV_W'(1)) * DIV_W'(rod);
                d.div_b  = DIV_W'(q.fin);
                d.div_go = 1'b1;
                d.st     = S_FWAIT;
            end
            S_FWAIT: begin
                if (div_rdy) begin
                    if (div_q == '0) begin
                        d.st = S_NEXT;
                    end else begin
                        if (div_q > DIV_W'(F_MAX)) fnew = FBW'(F_MAX);
                        else                       fnew = div_q[FBW-1:0];
                        d.f_cur  = fnew;
                        d.div_a  = DIV_W'(q.fin) * DIV_W'(fnew);
                        d.div_b  = DIV_W'(rod);
                        d.div_go = 1'b1;
                        d.st     = S_RWAIT;
                    end
                end
            end
            S_RWAIT: begin
                if (div_rdy) begin
                    d.st = S_NEXT;
                    if (cur > q.best_rate) begin
                        d.best_rate = cur;
                        d.best_f    = q.f_cur;
                        d.best_r    = q.r_cur;
                        d.best_od   = q.od_cur;
                        if (cur == {1'b0, q.req}) fin_now = 1'b1;
                    end
                end
            end
            S_NEXT: begin
                d.st = S_FGO;
                if (q.r_cur == RW'(R_MAX)) begin
                    if (q.od_cur == q.od_hi) begin
                        fin_now = 1'b1;
                    end else begin
                        d.od_cur = q.od_cur + ODW'(1);
                        d.r_cur  = RW'(1);
                    end
                end else begin
                    d.r_cur = q.r_cur + RW'(1);
                end
            end
            default: d.st = S_IDLE;
        endcase

        if (fin_now) begin
            d.st   = S_IDLE;
            d.done = 1'b1;
            if (d.best_rate != '0) begin
                d.ok     = 1'b1;
                d.fail   = 1'b0;
                d.o_rate = d.best_rate;
                d.o_f    = d.best_f;
                d.o_r    = d.best_r;
                d.o_od   = d.best_od;
            end else begin
                d.ok     = 1'b0;
                d.fail   = 1'b1;
                d.o_rate = '0;
                d.o_f    = '0;
                d.o_r    = '0;
                d.o_od   = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: S_IDLE, default: '0};
        else        q <= d;
    end

    assign busy    = (q.st != S_IDLE);
    assign done    = q.done;
    assign ok      = q.ok;
    assign fail    = q.fail;
    assign rate_o  = q.o_rate;
    assign fb_div  = q.o_f;
    assign ref_div = q.o_r;
    assign out_div = q.o_od;

endmodule

// File: rtl/pll_search_chk.sv
module pll_search_chk #(
    parameter int FREQ_W = 32,
    parameter int R_MAX  = 64,
    parameter int OD_MAX = 8,
    parameter int F_MAX  = 8192,
    parameter int RW     = 7,
    parameter int ODW    = 4,
    parameter int FBW    = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              ok,
    input logic              fail,
    input logic [FREQ_W:0]   rate_o,
    input logic [FBW-1:0]    fb_div,
    input logic [RW-1:0]     ref_div,
    input logic [ODW-1:0]    out_div
);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_ends_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_busy_after_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_results_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(rate_o) && $stable(fb_div) && $stable(ref_div)
                   && $stable(out_div) && $stable(ok) && $stable(fail)));

    assert_ranges_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ok |-> (ref_div >= RW'(1) && ref_div <= RW'(R_MAX)
                && out_div >= ODW'(1) && out_div <= ODW'(OD_MAX)
                && fb_div >= FBW'(1) && fb_div <= FBW'(F_MAX)));

    assert_fail_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (rate_o == '0 && fb_div == '0 && ref_div == '0 && out_div == '0));

    assert_one_verdict_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ok != fail));

endmodule

bind pll_param_search pll_search_chk #(
    .FREQ_W (FREQ_W),
    .R_MAX  (R_MAX),
    .OD_MAX (OD_MAX),
    .F_MAX  (F_MAX),
    .RW     ($clog2(R_MAX + 1)),
    .ODW    ($clog2(OD_MAX + 2)),
    .FBW    ($clog2(F_MAX + 1))
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .ok      (ok),
    .fail    (fail),
    .rate_o  (rate_o),
    .fb_div  (fb_div),
    .ref_div (ref_div),
    .out_div (out_div)
);

// File: tb/sim_pll_param_search.sv
`timescale 1ns/1ps
module sim_pll_param_search;
    localparam int FREQ_W = 16;
    localparam int DIV_W  = 32;
    localparam int R_MAX  = 8;
    localparam int OD_MAX = 4;
    localparam int F_MAX  = 64;
    localparam longint VLO = 1200;
    localparam longint VHI = 6000;
    localparam int RW  = $clog2(R_MAX + 1);
    localparam int ODW = $clog2(OD_MAX + 2);
    localparam int FBW = $clog2(F_MAX + 1);
    localparam int LIMIT = 190000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [FREQ_W-1:0] f_in = '0;
    logic [FREQ_W-1:0] f_req = '0;
    logic              busy, done, ok, fail;
    logic [FREQ_W:0]   rate_o;
    logic [FBW-1:0]    fb_div;
    logic [RW-1:0]     ref_div;
    logic [ODW-1:0]    out_div;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 0;
    bit timed_out = 0;

    always #2.5 clk = ~clk;

    pll_param_search #(
        .FREQ_W(FREQ_W), .DIV_W(DIV_W), .R_MAX(R_MAX), .OD_MAX(OD_MAX),
        .F_MAX(F_MAX), .VCO_LO(VLO), .VCO_HI(VHI)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .f_in(f_in), .f_req(f_req),
        .busy(busy), .done(done), .ok(ok), .fail(fail), .rate_o(rate_o),
        .fb_div(fb_div), .ref_div(ref_div), .out_div(out_div)
    );

    task automatic chk(input bit cond, input string tag, input string detail);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s: %s", tag, detail);
        end
    endtask

    function automatic void model(input longint fin, input longint req, output bit mok,
                                  output longint mrate, output longint mf,
                                  output longint mr, output longint mod);
        longint lo, hi, best, rod, f, cur;
        bit stop;
        mok = 0; mrate = 0; mf = 0; mr = 0; mod = 0; best = 0; stop = 0;
        if (fin == 0 || req == 0) return;
        lo = VLO / req + 1;
        hi = VHI / req;
        if (hi > OD_MAX) hi = OD_MAX;
        for (longint od = lo; od <= hi && !stop; od++) begin
            for (longint r = 1; r <= R_MAX && !stop; r++) begin
                rod = 2 * r * od;
                f = (req + 1) * rod / fin;
                if (f >= 1) begin
                    if (f > F_MAX) f = F_MAX;
                    cur = fin * f / rod;
                    if (cur > best) begin
                        best = cur; mf = f; mr = r; mod = od;
                        if (cur == req) stop = 1;
                    end
                end
            end
        end
        mrate = best;
        mok = (best != 0);
        if (!mok) begin mf = 0; mr = 0; mod = 0; end
    endfunction

    task automatic launch(input longint fin, input longint req);
        @(negedge clk);
        f_in  = FREQ_W'(fin);
        f_req = FREQ_W'(req);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 1;
        while (!done && !timed_out) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic compare(input longint fin, input longint req, input string tag);
        bit mok;
        longint mrate, mf, mr, mod;
        model(fin, req, mok, mrate, mf, mr, mod);
        chk(ok == mok && fail == !mok && longint'(rate_o) == mrate &&
            longint'(fb_div) == mf && longint'(ref_div) == mr && longint'(out_div) == mod,
            tag, $sformatf("fin=%0d req=%0d got ok=%0d fail=%0d rate=%0d F=%0d R=%0d OD=%0d exp ok=%0d rate=%0d F=%0d R=%0d OD=%0d",
                           fin, req, ok, fail, rate_o, fb_div, ref_div, out_div, mok, mrate, mf, mr, mod));
        if (ok) begin
            longint lo, hi;
            // R2: rate follows the formula from the returned dividers
            chk(longint'(rate_o) == fin * longint'(fb_div) / (2 * longint'(ref_div) * longint'(out_div)),
                "R2", $sformatf("rate=%0d exp=%0d", rate_o,
                fin * longint'(fb_div) / (2 * longint'(ref_div) * longint'(out_div))));
            // R11: never above req+1
            chk(longint'(rate_o) <= req + 1, "R11", $sformatf("rate=%0d exp<=%0d", rate_o, req + 1));
            // R3: OD inside the oscillator window
            lo = VLO / req + 1;
            hi = VHI / req; if (hi > OD_MAX) hi = OD_MAX;
            chk(longint'(out_div) >= lo && longint'(out_div) <= hi, "R3",
                $sformatf("od=%0d exp %0d..%0d", out_div, lo, hi));
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > LIMIT && !finished) begin
                timed_out = 1;
                finished = 1;
                fails++;
                checks++;
                $display("FAIL watchdog: got cycles=%0d exp<=%0d", cycles, LIMIT);
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        longint fins[3] = '{97, 250, 1000};
        longint reqs[10] = '{300, 401, 523, 700, 999, 1200, 1500, 2047, 3000, 5999};
        int cyc;
        int ndone;
        logic [FREQ_W:0] hold_rate;
        logic [FBW-1:0] hold_f;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !ok && !fail && rate_o == 0 && fb_div == 0 && ref_div == 0 && out_div == 0,
            "R1", $sformatf("busy=%0d done=%0d ok=%0d fail=%0d rate=%0d exp all 0", busy, done, ok, fail, rate_o));

        // R4 R5: grid sweep against the search order model (includes F clamp at fin=97)
        foreach (fins[i]) begin
            foreach (reqs[j]) begin
                launch(fins[i], reqs[j]);
                chk(busy, "R10", $sformatf("busy=%0d exp 1", busy));
                wait_done(cyc);
                compare(fins[i], reqs[j], "R4/R5");
            end
        end

        // R6: exact match on the first pair ends quickly
        launch(1000, 1000);
        wait_done(cyc);
        compare(1000, 1000, "R6");
        chk(cyc < 400, "R6", $sformatf("latency=%0d exp<400", cyc));

        // R7: empty OD window (too high, too low) and all F zero
        launch(100, 7000);   wait_done(cyc); compare(100, 7000, "R7");
        chk(fail && !ok, "R7", $sformatf("fail=%0d ok=%0d exp 1/0", fail, ok));
        launch(100, 100);    wait_done(cyc); compare(100, 100, "R7");
        launch(65000, 400);  wait_done(cyc); compare(65000, 400, "R7");
        chk(fail && rate_o == 0, "R7", $sformatf("fail=%0d rate=%0d exp 1/0", fail, rate_o));

        // R8: zero inputs fail with no division
        launch(0, 1000);  wait_done(cyc);
        chk(fail && !ok && cyc <= 2, "R8", $sformatf("fail=%0d cyc=%0d exp 1,<=2", fail, cyc));
        launch(1000, 0);  wait_done(cyc);
        chk(fail && !ok && cyc <= 2, "R8", $sformatf("fail=%0d cyc=%0d exp 1,<=2", fail, cyc));

        // R9: start while busy is ignored
        launch(250, 700);
        repeat (20) @(negedge clk);
        f_in = 16'd1000; f_req = 16'd1000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ndone = 0;
        while (!done && !timed_out) @(negedge clk);
        compare(250, 700, "R9");
        repeat (60) begin
            @(negedge clk);
            if (done) ndone++;
        end
        chk(ndone == 0, "R9", $sformatf("extra done=%0d exp 0", ndone));

        // R10: results hold after done while inputs change
        hold_rate = rate_o; hold_f = fb_div;
        f_in = 16'd333; f_req = 16'd4444;
        repeat (10) @(negedge clk);
        chk(rate_o == hold_rate && fb_div == hold_f && !busy, "R10",
            $sformatf("rate=%0d F=%0d exp %0d %0d", rate_o, fb_div, hold_rate, hold_f));

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule